// File: doc/BRIEF.md
# PHY Management Register Model

This block models the management register set of a 10/100 Ethernet PHY as seen from a host that issues management reads and writes. Each access presents a 16-bit address word holding a 5-bit PHY address and a 5-bit register index. Writes carry 16-bit data. Reads return registered data one cycle later. Sixteen 16-bit registers are held, and each one has a fixed value that is loaded on reset.

A few registers behave in special ways. The status register and the two identifier registers cannot be written. A write to the control register with bit 15 set reloads every register instead of being stored. An asynchronous link-up input is brought into the clock domain through a two-flop synchronizer, and each change of the synchronized level updates the link bit in the status register and the link partner ability word. A link-fail flag is refreshed by every read, and while the scan enable is high it follows the link on every cycle.

Only PHY address 1 answers. Reads aimed at any other PHY return all ones, and writes aimed at any other PHY change nothing.

Top module: `mii_mgmt_regs`

## Requirements
- R1: After reset, with the synchronized link low, index 0 (control) reads 0x1000, index 1 (status) reads 0x7848, index 2 reads 0x2000, index 3 reads 0x5C90, index 4 (advertisement) reads 0x01E1, index 5 (partner ability) reads 0x0000, and indices 6 to 15 read 0x0000.
- R2: A write of a value with bit 15 set to index 0 is not stored. It reloads all sixteen registers to their R1 values and then reapplies the current synchronized link state as described in R5.
- R3: Host writes to index 1, index 2 and index 3 have no effect on the value read back.
- R4: A write to index 0 with bit 15 clear, and a write to any of indices 4 to 15, stores the 16-bit value exactly as written.
- R5: Each change of the synchronized link level is applied once. Link up sets status bit 2 and ORs 0x01E1 into the partner ability word. Link down clears status bit 2 and ANDs the partner ability word with 0x01FF. The input passes two synchronizer flops and the registers update on the following edge.
- R6: Only PHY address 1 responds. A read aimed at any other PHY address returns 0xFFFF, and a write aimed at any other PHY address changes no register.
- R7: In the address word, bits 12:8 give the register index and bits 4:0 give the PHY address. All five bits of the PHY address are compared.
- R8: Register indices 16 to 31 are ignored on write and read back as 0x0000.
- R9: `rd_valid` is high for exactly one cycle after each cycle with `rd_stb` high, and `rd_data` holds the value of the register as it stood in the strobe cycle. `rd_data` keeps that value until the next read.
- R10: Every read strobe, whatever its PHY address, loads `link_fail` with the inverse of the synchronized link. With `scan_en` low, `link_fail` otherwise holds its value. Reset clears it to 0.
- R11: While `scan_en` is high, `link_fail` is loaded with the inverse of the synchronized link on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_addr | input | 16 | Address word: register index in bits 12:8, PHY address in bits 4:0 |
| wr_data | input | 16 | Write data |
| wr_stb | input | 1 | Write strobe, one access per cycle |
| rd_stb | input | 1 | Read strobe |
| scan_en | input | 1 | Continuous link-fail tracking enable |
| link_up | input | 1 | Asynchronous link state, 1 = link up |
| rd_data | output | 16 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_stb` |
| link_fail | output | 1 | Link-fail status flag |

## Verification
The assertions check the following on every cycle:
- The non-link bits of the status register and both identifier words never change.
- The status link bit always equals the synchronized link from one cycle earlier.
- Every read strobe is followed by exactly one valid pulse.
- Reads aimed at a foreign PHY return all ones, and out-of-range reads return zero.
- A soft reset restores the control word.
- Scanning keeps `link_fail` locked to the link.

The bench scenarios cover what depends on earlier history:
- Values written and then read back.
- Writes that are ignored because of the PHY address or a read-only register.
- Register contents restored by a soft reset.
- The partner ability word masked and then ORed across a link-down and link-up cycle.
- `link_fail` holding its value between reads while scanning is off.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;

    localparam int REG_COUNT = 16;
    localparam int DATA_W    = 16;
    localparam int IDX_W     = 5;

    localparam int IDX_CTRL    = 0;
    localparam int IDX_STAT    = 1;
    localparam int IDX_ID_HI   = 2;
    localparam int IDX_ID_LO   = 3;
    localparam int IDX_ADV     = 4;
    localparam int IDX_PARTNER = 5;

    localparam int CTRL_RESET_BIT = 15;
    localparam logic [DATA_W-1:0] STAT_LINK_BIT  = 16'h0004;
    localparam logic [DATA_W-1:0] PARTNER_UP_OR  = 16'h01E1;
    localparam logic [DATA_W-1:0] PARTNER_DN_AND = 16'h01FF;
    localparam logic [DATA_W-1:0] ABSENT_VALUE   = 16'hFFFF;

    // Address word layout: index in 12:8, PHY in 4:0
    typedef struct packed {
        logic [2:0]       spare_hi;
        logic [IDX_W-1:0] reg_idx;
        logic [2:0]       spare_lo;
        logic [IDX_W-1:0] phy;
    } mgmt_addr_t;

    // Where a read takes its data from
    typedef enum logic [1:0] {
        RSRC_REG    = 2'd0,
        RSRC_ZERO   = 2'd1,
        RSRC_ABSENT = 2'd2
    } rd_src_e;

    function automatic logic [DATA_W-1:0] reset_value(input int idx);
        case (idx)
            IDX_CTRL:  return 16'h1000;
            IDX_STAT:  return 16'h7848;
            IDX_ID_HI: return 16'h2000;
            IDX_ID_LO: return 16'h5C90;
            IDX_ADV:   return 16'h01E1;
            default:   return '0;
        endcase
    endfunction

    function automatic logic host_read_only(input int idx);
        return (idx == IDX_STAT) || (idx == IDX_ID_HI) || (idx == IDX_ID_LO);
    endfunction

    function automatic logic [DATA_W-1:0] status_with_link(
        input logic [DATA_W-1:0] v, input logic up);
        return up ? (v | STAT_LINK_BIT) : (v & ~STAT_LINK_BIT);
    endfunction

    function automatic logic [DATA_W-1:0] partner_with_link(
        input logic [DATA_W-1:0] v, input logic up);
        return up ? (v | PARTNER_UP_OR) : (v & PARTNER_DN_AND);
    endfunction

endpackage

// File: rtl/mii_link_sync.sv
module mii_link_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/mii_reg_array.sv
module mii_reg_array
    import mii_mgmt_pkg::*;
#(
    parameter int NREG = mii_mgmt_pkg::REG_COUNT,
    parameter int DW   = mii_mgmt_pkg::DATA_W,
    parameter int IW   = mii_mgmt_pkg::IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_hit,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_val,
    input  logic          link_now,
    output logic [DW-1:0] regs_q [NREG]
);
    logic applied_q;
    logic soft_rst;
    logic relink;

    always_comb begin
        soft_rst = wr_hit && (wr_idx == IW'(IDX_CTRL)) && wr_val[CTRL_RESET_BIT];
        relink   = soft_rst || (link_now != applied_q);
    end

    always_ff @(posedge clk) begin
        if (rst) applied_q <= 1'b0;
        else     applied_q <= link_now;
    end

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            localparam logic [IW-1:0] MY_IDX = IW'(g);
            localparam logic [DW-1:0] RST_RAW = DW'(reset_value(g));
            logic [DW-1:0] base;
            logic [DW-1:0] nxt;
            logic [DW-1:0] rst_val;

            always_comb begin
                if (soft_rst)
                    base = RST_RAW;
                else if (wr_hit && (wr_idx == MY_IDX) && !host_read_only(g))
                    base = wr_val;
                else
                    base = regs_q[g];
            end

            if (g == IDX_STAT) begin : g_stat
                assign nxt     = relink ? status_with_link(base, link_now) : base;
                assign rst_val = status_with_link(RST_RAW, 1'b0);
            end else if (g == IDX_PARTNER) begin : g_partner
                assign nxt     = relink ? partner_with_link(base, link_now) : base;
                assign rst_val = partner_with_link(RST_RAW, 1'b0);
            end else begin : g_plain
                assign nxt     = base;
                assign rst_val = RST_RAW;
            end

            always_ff @(posedge clk) begin
                if (rst) regs_q[g] <= rst_val;
                else     regs_q[g] <= nxt;
            end
        end
    endgenerate
endmodule

// File: rtl/mii_read_port.sv
module mii_read_port
    import mii_mgmt_pkg::*;
#(
    parameter int NREG = mii_mgmt_pkg::REG_COUNT,
    parameter int DW   = mii_mgmt_pkg::DATA_W,
    parameter int IW   = mii_mgmt_pkg::IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic          phy_hit,
    input  logic [IW-1:0] rd_idx,
    input  logic [DW-1:0] regs_q [NREG],
    input  logic          link_now,
    input  logic          scan_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          link_fail
);
    localparam int SEL_W = $clog2(NREG);
    localparam logic [IW:0] LIMIT = (IW+1)'(NREG);

    rd_src_e       src;
    logic [DW-1:0] picked;

    always_comb begin
        if (!phy_hit)                 src = RSRC_ABSENT;
        else if ({1'b0, rd_idx} < LIMIT) src = RSRC_REG;
        else                          src = RSRC_ZERO;
        case (src)
            RSRC_REG:    picked = regs_q[rd_idx[SEL_W-1:0]];
            RSRC_ABSENT: picked = ABSENT_VALUE;
            default:     picked = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data   <= '0;
            rd_valid  <= 1'b0;
            link_fail <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= picked;
            if (rd_en || scan_en) link_fail <= !link_now;
        end
    end
endmodule

// File: rtl/mii_mgmt_regs.sv
module mii_mgmt_regs
    import mii_mgmt_pkg::*;
#(
    parameter int PHY_ID      = 1,
    parameter int SYNC_STAGES = 2,
    parameter int NREG        = mii_mgmt_pkg::REG_COUNT,
    parameter int DW          = mii_mgmt_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [15:0]   mgmt_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_stb,
    input  logic          rd_stb,
    input  logic          scan_en,
    input  logic          link_up,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          link_fail
);
    localparam logic [IDX_W-1:0] MY_PHY = IDX_W'(PHY_ID);
    localparam logic [IDX_W:0]   LIMIT  = (IDX_W+1)'(NREG);

    mgmt_addr_t    addr;
    logic          phy_hit;
    logic          wr_hit;
    logic          link_sync;
    logic [DW-1:0] reg_q [NREG];

    always_comb begin
        addr    = mgmt_addr_t'(mgmt_addr);
        phy_hit = (addr.phy == MY_PHY);
        wr_hit  = wr_stb && phy_hit && ({1'b0, addr.reg_idx} < LIMIT);
    end

    mii_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(link_up), .sync_out(link_sync)
    );

    mii_reg_array #(.NREG(NREG), .DW(DW), .IW(IDX_W)) u_regs (
        .clk(clk), .rst(rst), .wr_hit(wr_hit), .wr_idx(addr.reg_idx),
        .wr_val(wr_data), .link_now(link_sync), .regs_q(reg_q)
    );

    mii_read_port #(.NREG(NREG), .DW(DW), .IW(IDX_W)) u_rd (
        .clk(clk), .rst(rst), .rd_en(rd_stb), .phy_hit(phy_hit),
        .rd_idx(addr.reg_idx), .regs_q(reg_q), .link_now(link_sync),
        .scan_en(scan_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .link_fail(link_fail)
    );
endmodule

// File: rtl/mii_mgmt_regs_chk.sv
module mii_mgmt_regs_chk #(
    parameter int PHY_ID = 1
) (
    input logic        clk,
    input logic        rst,
    input logic [15:0] mgmt_addr,
    input logic [15:0] wr_data,
    input logic        wr_stb,
    input logic        rd_stb,
    input logic        scan_en,
    input logic [15:0] rd_data,
    input logic        rd_valid,
    input logic        link_fail,
    input logic        link_sync,
    input logic [15:0] ctrl_q,
    input logic [15:0] stat_q,
    input logic [15:0] id_hi_q,
    input logic [15:0] id_lo_q
);
    logic phy_ok;
    assign phy_ok = (mgmt_addr[4:0] == 5'(PHY_ID));

    // R3
    stat_fixed_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_q | 16'h0004) == 16'h784C);
    // R3
    id_words_chk: assert property (@(posedge clk) disable iff (rst)
        (id_hi_q == 16'h2000) && (id_lo_q == 16'h5C90));
    // R5
    stat_link_bit_chk: assert property (@(posedge clk) disable iff (rst)
        stat_q[2] == $past(link_sync));
    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> rd_valid);
    // R9
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> !rd_valid);
    // R6
    absent_phy_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !phy_ok) |=> (rd_data == 16'hFFFF));
    // R8
    out_of_range_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && phy_ok && mgmt_addr[12]) |=> (rd_data == 16'h0000));
    // R2
    soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && phy_ok && mgmt_addr[12:8] == 5'd0 && wr_data[15]) |=> (ctrl_q == 16'h1000));
    // R11
    scan_track_chk: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> (link_fail == !$past(link_sync)));
endmodule

bind mii_mgmt_regs mii_mgmt_regs_chk #(.PHY_ID(PHY_ID)) u_chk (
    .clk(clk), .rst(rst), .mgmt_addr(mgmt_addr), .wr_data(wr_data),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .scan_en(scan_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .link_fail(link_fail), .link_sync(link_sync),
    .ctrl_q(reg_q[0]), .stat_q(reg_q[1]), .id_hi_q(reg_q[2]), .id_lo_q(reg_q[3])
);

// File: tb/mii_mgmt_regs_test.sv
module mii_mgmt_regs_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mgmt_addr = '0;
    logic [15:0] wr_data = '0;
    logic        wr_stb = 1'b0;
    logic        rd_stb = 1'b0;
    logic        scan_en = 1'b0;
    logic        link_up = 1'b0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        link_fail;

    int compared = 0;
    int mismatched = 0;

    always #4 clk = ~clk;

    mii_mgmt_regs uut (
        .clk(clk), .rst(rst), .mgmt_addr(mgmt_addr), .wr_data(wr_data),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .scan_en(scan_en), .link_up(link_up),
        .rd_data(rd_data), .rd_valid(rd_valid), .link_fail(link_fail)
    );

    // {req[3:0], is_write, reg[4:0], phy[4:0], data[15:0]}
    localparam int NVEC = 35;
    localparam logic [30:0] VEC [NVEC] = '{
        {4'd1, 1'b0, 5'd0,  5'd1,  16'h1000},  // R1
        {4'd5, 1'b0, 5'd1,  5'd1,  16'h784C},  // R5 link up
        {4'd1, 1'b0, 5'd2,  5'd1,  16'h2000},  // R1
        {4'd1, 1'b0, 5'd3,  5'd1,  16'h5C90},  // R1
        {4'd1, 1'b0, 5'd4,  5'd1,  16'h01E1},  // R1
        {4'd5, 1'b0, 5'd5,  5'd1,  16'h01E1},  // R5
        {4'd1, 1'b0, 5'd9,  5'd1,  16'h0000},  // R1
        {4'd3, 1'b1, 5'd1,  5'd1,  16'h0000},  // R3
        {4'd3, 1'b0, 5'd1,  5'd1,  16'h784C},  // R3
        {4'd3, 1'b1, 5'd2,  5'd1,  16'h1234},  // R3
        {4'd3, 1'b0, 5'd2,  5'd1,  16'h2000},  // R3
        {4'd3, 1'b1, 5'd3,  5'd1,  16'hFFFF},  // R3
        {4'd3, 1'b0, 5'd3,  5'd1,  16'h5C90},  // R3
        {4'd4, 1'b1, 5'd4,  5'd1,  16'hABCD},  // R4
        {4'd4, 1'b0, 5'd4,  5'd1,  16'hABCD},  // R4
        {4'd4, 1'b1, 5'd9,  5'd1,  16'h5555},  // R4
        {4'd4, 1'b0, 5'd9,  5'd1,  16'h5555},  // R4
        {4'd4, 1'b1, 5'd15, 5'd1,  16'hA5A5},  // R4
        {4'd4, 1'b0, 5'd15, 5'd1,  16'hA5A5},  // R4
        {4'd4, 1'b1, 5'd0,  5'd1,  16'h0100},  // R4
        {4'd4, 1'b0, 5'd0,  5'd1,  16'h0100},  // R4
        {4'd6, 1'b1, 5'd9,  5'd2,  16'h1111},  // R6
        {4'd6, 1'b0, 5'd9,  5'd1,  16'h5555},  // R6
        {4'd6, 1'b0, 5'd0,  5'd2,  16'hFFFF},  // R6
        {4'd7, 1'b0, 5'd9,  5'd17, 16'hFFFF},  // R7 upper PHY bit compared
        {4'd8, 1'b1, 5'd17, 5'd1,  16'h7777},  // R8
        {4'd8, 1'b0, 5'd17, 5'd1,  16'h0000},  // R8
        {4'd8, 1'b0, 5'd31, 5'd1,  16'h0000},  // R8
        {4'd2, 1'b1, 5'd0,  5'd1,  16'h8000},  // R2
        {4'd2, 1'b0, 5'd0,  5'd1,  16'h1000},  // R2
        {4'd2, 1'b0, 5'd4,  5'd1,  16'h01E1},  // R2
        {4'd2, 1'b0, 5'd9,  5'd1,  16'h0000},  // R2
        {4'd2, 1'b0, 5'd15, 5'd1,  16'h0000},  // R2
        {4'd2, 1'b0, 5'd1,  5'd1,  16'h784C},  // R2
        {4'd2, 1'b0, 5'd5,  5'd1,  16'h01E1}   // R2
    };

    function automatic logic [15:0] mk_addr(input logic [4:0] r, input logic [4:0] p);
        return {3'b000, r, 3'b000, p};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] r, input logic [4:0] p, input logic [15:0] d);
        @(negedge clk);
        mgmt_addr = mk_addr(r, p);
        wr_data   = d;
        wr_stb    = 1'b1;
        @(negedge clk);
        wr_stb    = 1'b0;
    endtask

    task automatic do_read(input string tag, input logic [4:0] r, input logic [4:0] p,
                           input logic [15:0] exp);
        @(negedge clk);
        mgmt_addr = mk_addr(r, p);
        rd_stb    = 1'b1;
        @(negedge clk);
        rd_stb    = 1'b0;
        check({tag, " valid"}, {15'd0, rd_valid}, 16'd1);
        check(tag, rd_data, exp);
        @(negedge clk);
        check({tag, " valid drop (R9)"}, {15'd0, rd_valid}, 16'd0);
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 R10 outputs idle in reset
        check("R9 valid in reset", {15'd0, rd_valid}, 16'd0);
        check("R9 data in reset", rd_data, 16'h0000);
        check("R10 link_fail in reset", {15'd0, link_fail}, 16'd0);
        rst = 1'b0;
        // R1 reset values with link down
        do_read("R1 status link down", 5'd1, 5'd1, 16'h7848);
        do_read("R1 partner link down", 5'd5, 5'd1, 16'h0000);
        check("R10 read loads link_fail", {15'd0, link_fail}, 16'd1);

        link_up = 1'b1;
        settle();
        for (int i = 0; i < NVEC; i++) begin
            logic [30:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d row %0d", v[30:27], i);
            if (v[26]) do_write(v[25:21], v[20:16], v[15:0]);
            else       do_read(tag, v[25:21], v[20:16], v[15:0]);
        end

        // R10 link_fail refreshed only on reads when not scanning
        do_read("R10 read", 5'd0, 5'd1, 16'h1000);
        check("R10 link up", {15'd0, link_fail}, 16'd0);
        link_up = 1'b0;
        settle();
        check("R10 holds without read", {15'd0, link_fail}, 16'd0);
        do_read("R10 read foreign phy", 5'd0, 5'd3, 16'hFFFF);
        check("R10 loaded on read", {15'd0, link_fail}, 16'd1);
        link_up = 1'b1;
        settle();
        check("R10 holds after link up", {15'd0, link_fail}, 16'd1);

        // R11 scanning follows link
        scan_en = 1'b1;
        settle();
        check("R11 scan link up", {15'd0, link_fail}, 16'd0);
        link_up = 1'b0;
        settle();
        check("R11 scan link down", {15'd0, link_fail}, 16'd1);
        link_up = 1'b1;
        settle();
        check("R11 scan link back", {15'd0, link_fail}, 16'd0);
        scan_en = 1'b0;

        // R5 partner masking and OR across link changes
        do_write(5'd5, 5'd1, 16'hFE00);
        do_read("R5 partner stored", 5'd5, 5'd1, 16'hFE00);
        link_up = 1'b0;
        settle();
        do_read("R5 partner masked", 5'd5, 5'd1, 16'h0000);
        do_read("R5 status down", 5'd1, 5'd1, 16'h7848);
        link_up = 1'b1;
        settle();
        do_read("R5 partner ored", 5'd5, 5'd1, 16'h01E1);
        do_read("R5 status up", 5'd1, 5'd1, 16'h784C);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule